// File: doc/BRIEF.md
# UART Modem-Control Loopback Unit

This unit produces the four modem-status flags of a UART (ring indicator, carrier detect, clear to send, data set ready) and the matching modem-status interrupt bits. In normal operation the flags follow the external modem pins after a synchronizer. In internal loopback mode the pins are ignored. Each control-register write instead copies the software-driven modem control outputs onto the status flags through a fixed cross-mapping.

On every loopback update the whole modem-status interrupt group is rebuilt from the new flags. A one-cycle pulse marks each rebuild so that the interrupt outputs downstream can be evaluated again. The update happens on any control write made while loopback is on, including the write that only turns loopback on.

Flag, pin and interrupt vectors all use the same bit order: bit 3 ring indicator, bit 2 carrier detect, bit 1 clear to send, bit 0 data set ready.

Top module: `uart_mdm_loop`

## Requirements
- R1: After reset the flags, the interrupt bits and the update pulse are all 0.
- R2: A control write (ctrl_wr_i=1) with ctrl_lbe_i=1 sets the flags, from the next rising edge, as follows: bit 3 = Out2, bit 2 = Out1, bit 1 = RTS, bit 0 = DTR.
- R3: While ctrl_lbe_i=1 and no write is strobed, the flags and the interrupt bits hold their values whatever the pins do.
- R4: On each loopback update the interrupt vector is cleared and then rebuilt, so each bit ends up equal to its new flag. A previously set bit whose new flag is 0 is cleared.
- R5: A write whose only set control bit is loopback enable still applies the mapping at once. From non-loopback operation, such a write sets all four flags and interrupt bits to 0.
- R6: irq_upd_o is 1 for exactly the cycle after each loopback update edge and 0 otherwise.
- R7: While ctrl_lbe_i=0, the flags equal the value mdm_pins_i held SYNC_STAGES+1 rising edges earlier.
- R8: While ctrl_lbe_i=0, control writes leave the interrupt bits unchanged and raise no update pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ctrl_wr_i | input | 1 | Strobe for a control-register write |
| ctrl_lbe_i | input | 1 | Loopback enable control bit |
| ctrl_out2_i | input | 1 | Out2 control bit |
| ctrl_out1_i | input | 1 | Out1 control bit |
| ctrl_rts_i | input | 1 | Request-to-send control bit |
| ctrl_dtr_i | input | 1 | Data-terminal-ready control bit |
| mdm_pins_i | input | 4 | Asynchronous external modem status pins {RI, DCD, CTS, DSR} |
| stat_flags_o | output | 4 | Modem status flags {RI, DCD, CTS, DSR} |
| ms_irq_o | output | 4 | Modem-status interrupt bits {RI, DCD, CTS, DSR} |
| irq_upd_o | output | 1 | One-cycle pulse after each interrupt rebuild |

## Verification
A loopback write changes the flags, the interrupt bits and the update pulse at the first rising edge after the strobe. A pin change reaches the flags only at the third rising edge, the synchronizer depth plus one. The driver computes the outcome of each cycle's stimulus from the requirements and queues it. The monitor samples one time unit after the following rising edge and pops one item per edge, so every comparison lands in the cycle in which that result is due.

// File: rtl/uart_mdm_loop_pkg.sv
package uart_mdm_loop_pkg;
   localparam int unsigned MDM_W = 4;
   localparam int unsigned IDX_RI  = 3;
   localparam int unsigned IDX_DCD = 2;
   localparam int unsigned IDX_CTS = 1;
   localparam int unsigned IDX_DSR = 0;

   typedef logic [MDM_W-1:0] mdm_vec_t;

   typedef struct packed {
      logic lbe;
      logic out2;
      logic out1;
      logic rts;
      logic dtr;
   } mdm_ctrl_t;
endpackage

// File: rtl/uart_mdm_sync.sv
module uart_mdm_sync #(
   parameter int unsigned WIDTH  = 4,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [WIDTH-1:0] async_i,
   output logic [WIDTH-1:0] sync_o
);
   localparam int unsigned LAST = STAGES - 1;

   if (STAGES < 2) begin : g_bad_depth
      $error("uart_mdm_sync: STAGES must be at least 2");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("uart_mdm_sync: WIDTH must be at least 1");
   end

   logic [WIDTH-1:0] stg_q [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            stg_q[s] <= '0;
         end else if (s == 0) begin
            stg_q[s] <= async_i;
         end else begin
            stg_q[s] <= stg_q[(s == 0) ? 0 : s-1];
         end
      end
   end

   assign sync_o = stg_q[LAST];
endmodule

// File: rtl/uart_mdm_xmap.sv
module uart_mdm_xmap
   import uart_mdm_loop_pkg::*;
(
   input  mdm_ctrl_t ctrl_i,
   input  logic      wr_i,
   input  mdm_vec_t  irq_cur_i,
   output logic      upd_o,
   output mdm_vec_t  flags_nxt_o,
   output mdm_vec_t  irq_nxt_o
);
   mdm_vec_t cleared;

   always_comb begin
      flags_nxt_o          = '0;
      flags_nxt_o[IDX_RI]  = ctrl_i.out2;
      flags_nxt_o[IDX_DCD] = ctrl_i.out1;
      flags_nxt_o[IDX_CTS] = ctrl_i.rts;
      flags_nxt_o[IDX_DSR] = ctrl_i.dtr;
   end

   assign upd_o   = wr_i & ctrl_i.lbe;
   assign cleared = irq_cur_i & ~{MDM_W{1'b1}};

   for (genvar b = 0; b < MDM_W; b++) begin : g_irq_bit
      assign irq_nxt_o[b] = cleared[b] | flags_nxt_o[b];
   end
endmodule

// File: rtl/uart_mdm_loop.sv
module uart_mdm_loop
   import uart_mdm_loop_pkg::*;
#(
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic       clk_i,
   input  logic       rst_ni,
   input  logic       ctrl_wr_i,
   input  logic       ctrl_lbe_i,
   input  logic       ctrl_out2_i,
   input  logic       ctrl_out1_i,
   input  logic       ctrl_rts_i,
   input  logic       ctrl_dtr_i,
   input  logic [3:0] mdm_pins_i,
   output logic [3:0] stat_flags_o,
   output logic [3:0] ms_irq_o,
   output logic       irq_upd_o
);
   mdm_ctrl_t ctrl;
   mdm_vec_t  pins_sync;
   mdm_vec_t  map_flags;
   mdm_vec_t  map_irq;
   logic      lb_upd;
   mdm_vec_t  flags_q;
   mdm_vec_t  irq_q;
   logic      upd_q;

   assign ctrl = '{lbe: ctrl_lbe_i, out2: ctrl_out2_i, out1: ctrl_out1_i,
                   rts: ctrl_rts_i, dtr: ctrl_dtr_i};

   uart_mdm_sync #(
      .WIDTH  (MDM_W),
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .async_i (mdm_pins_i),
      .sync_o  (pins_sync)
   );

   uart_mdm_xmap u_xmap (
      .ctrl_i      (ctrl),
      .wr_i        (ctrl_wr_i),
      .irq_cur_i   (irq_q),
      .upd_o       (lb_upd),
      .flags_nxt_o (map_flags),
      .irq_nxt_o   (map_irq)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         flags_q <= '0;
         irq_q   <= '0;
         upd_q   <= 1'b0;
      end else begin
         upd_q <= lb_upd;
         if (lb_upd) begin
            flags_q <= map_flags;
            irq_q   <= map_irq;
         end else if (!ctrl.lbe) begin
            flags_q <= pins_sync;
         end
      end
   end

   assign stat_flags_o = flags_q;
   assign ms_irq_o     = irq_q;
   assign irq_upd_o    = upd_q;
endmodule

// File: rtl/uart_mdm_loop_chk.sv
module uart_mdm_loop_chk (
   input logic       clk_i,
   input logic       rst_ni,
   input logic       ctrl_wr_i,
   input logic       ctrl_lbe_i,
   input logic       ctrl_out2_i,
   input logic       ctrl_out1_i,
   input logic       ctrl_rts_i,
   input logic       ctrl_dtr_i,
   input logic [3:0] stat_flags_o,
   input logic [3:0] ms_irq_o,
   input logic       irq_upd_o
);
   always_comb begin
      if (!rst_ni) begin
         a_r1_reset_clear: assert (stat_flags_o == 4'b0 && ms_irq_o == 4'b0 && !irq_upd_o);
      end
   end

   a_r2_cross_map: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ctrl_wr_i && ctrl_lbe_i) |=>
         stat_flags_o == $past({ctrl_out2_i, ctrl_out1_i, ctrl_rts_i, ctrl_dtr_i}));

   a_r3_hold_flags: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ctrl_lbe_i && !ctrl_wr_i) |=> $stable(stat_flags_o) && $stable(ms_irq_o));

   a_r4_irq_rebuild: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ctrl_wr_i && ctrl_lbe_i) |=>
         ms_irq_o == $past({ctrl_out2_i, ctrl_out1_i, ctrl_rts_i, ctrl_dtr_i}));

   a_r6_pulse_on: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ctrl_wr_i && ctrl_lbe_i) |=> irq_upd_o);

   a_r6_pulse_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(ctrl_wr_i && ctrl_lbe_i) |=> !irq_upd_o);

   a_r8_irq_untouched: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !ctrl_lbe_i |=> $stable(ms_irq_o));
endmodule

bind uart_mdm_loop uart_mdm_loop_chk u_chk (
   .clk_i        (clk_i),
   .rst_ni       (rst_ni),
   .ctrl_wr_i    (ctrl_wr_i),
   .ctrl_lbe_i   (ctrl_lbe_i),
   .ctrl_out2_i  (ctrl_out2_i),
   .ctrl_out1_i  (ctrl_out1_i),
   .ctrl_rts_i   (ctrl_rts_i),
   .ctrl_dtr_i   (ctrl_dtr_i),
   .stat_flags_o (stat_flags_o),
   .ms_irq_o     (ms_irq_o),
   .irq_upd_o    (irq_upd_o)
);

// File: tb/uart_mdm_loop_bench.sv
module uart_mdm_loop_bench;
   localparam int CLK_PERIOD = 10;
   localparam int SYNC_D     = 2;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr = 1'b0, lbe = 1'b0, out2 = 1'b0, out1 = 1'b0, rts = 1'b0, dtr = 1'b0;
   logic [3:0] pins = 4'b0;
   logic [3:0] flags;
   logic [3:0] irq;
   logic       upd;

   int vectors = 0;
   int fails   = 0;

   typedef struct {
      logic [3:0] e_flags;
      logic [3:0] e_irq;
      logic       e_upd;
      bit         chk;
      string      tag;
   } exp_t;

   exp_t sb[$];

   logic [3:0] m_flags = 4'b0;
   logic [3:0] m_irq   = 4'b0;
   logic [3:0] hist [SYNC_D];

   always #(CLK_PERIOD/2) clk = ~clk;

   uart_mdm_loop #(.SYNC_STAGES(SYNC_D)) u_uart_mdm_loop (
      .clk_i        (clk),
      .rst_ni       (rst_n),
      .ctrl_wr_i    (wr),
      .ctrl_lbe_i   (lbe),
      .ctrl_out2_i  (out2),
      .ctrl_out1_i  (out1),
      .ctrl_rts_i   (rts),
      .ctrl_dtr_i   (dtr),
      .mdm_pins_i   (pins),
      .stat_flags_o (flags),
      .ms_irq_o     (irq),
      .irq_upd_o    (upd)
   );

   task automatic summary();
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
   endtask

   task automatic compare(input exp_t e);
      vectors++;
      if (flags !== e.e_flags || irq !== e.e_irq || upd !== e.e_upd) begin
         fails++;
         $display("FAIL %s: flags/irq/upd got %b/%b/%b expected %b/%b/%b",
                  e.tag, flags, irq, upd, e.e_flags, e.e_irq, e.e_upd);
      end
   endtask

   // Driver: called at a falling edge; applies one cycle of stimulus and
   // queues the outcome expected after the next rising edge.
   task automatic step(input logic w, input logic l, input logic [3:0] ctl,
                       input logic [3:0] p, input bit chk, input string tag);
      exp_t e;
      logic u;
      wr = w; lbe = l; out2 = ctl[3]; out1 = ctl[2]; rts = ctl[1]; dtr = ctl[0];
      pins = p;
      u = w && l;
      if (u) begin
         m_flags = ctl;
         m_irq   = ctl;
      end else if (!l) begin
         m_flags = hist[SYNC_D-1];
      end
      for (int k = SYNC_D-1; k > 0; k--) hist[k] = hist[k-1];
      hist[0] = p;
      e.e_flags = m_flags; e.e_irq = m_irq; e.e_upd = u; e.chk = chk; e.tag = tag;
      sb.push_back(e);
      @(negedge clk);
   endtask

   // Monitor: samples one time unit after each rising edge.
   initial begin
      forever begin
         @(posedge clk);
         #1;
         if (rst_n && sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            if (e.chk) compare(e);
         end
      end
   end

   initial begin
      #(CLK_PERIOD * 20000);
      fails++;
      $display("FAIL watchdog: run did not finish, got hung expected done");
      summary();
      $finish;
   end

   initial begin
      exp_t r;
      for (int k = 0; k < SYNC_D; k++) hist[k] = 4'b0;
      pins = 4'b1111;
      repeat (3) @(negedge clk);
      r.e_flags = 4'b0; r.e_irq = 4'b0; r.e_upd = 1'b0; r.chk = 1; r.tag = "R1 in reset";
      compare(r);
      pins = 4'b0;
      rst_n = 1'b1;
      @(negedge clk);
      r.tag = "R1 after release";
      compare(r);

      // R7: pins followed through the synchronizer
      step(0, 0, 4'b0000, 4'b1010, 1, "R7 pins 1010 c0");
      step(0, 0, 4'b0000, 4'b1010, 1, "R7 pins 1010 c1");
      step(0, 0, 4'b0000, 4'b1010, 1, "R7 pins 1010 c2");
      step(0, 0, 4'b0000, 4'b0110, 1, "R7 pins 0110 c0");
      step(0, 0, 4'b0000, 4'b0110, 1, "R7 pins 0110 c1");
      step(0, 0, 4'b0000, 4'b0110, 1, "R7 pins 0110 c2");

      // R2/R4/R6: loopback write, Out2 only
      step(1, 1, 4'b1000, 4'b0110, 1, "R2 R4 R6 out2 write");
      // R3: hold while pins move
      step(0, 1, 4'b0000, 4'b0101, 1, "R3 R6 hold c0");
      step(0, 1, 4'b0111, 4'b1111, 1, "R3 hold c1");
      step(0, 1, 4'b0000, 4'b0000, 1, "R3 hold c2");
      step(0, 1, 4'b0000, 4'b1001, 1, "R3 hold c3");

      // R2: each single mapping and all ones
      step(1, 1, 4'b0100, 4'b1001, 1, "R2 out1 -> dcd");
      step(1, 1, 4'b0010, 4'b1001, 1, "R2 rts -> cts");
      step(1, 1, 4'b0001, 4'b1001, 1, "R2 dtr -> dsr");
      step(1, 1, 4'b1111, 4'b1001, 1, "R2 R6 all ones");
      step(0, 1, 4'b1111, 4'b1001, 1, "R6 pulse drops");

      // R8: leave loopback; writes with lbe=0 do not touch irq
      step(1, 0, 4'b0000, 4'b0101, 1, "R8 write lbe0 c0");
      step(0, 0, 4'b0000, 4'b0101, 1, "R8 R7 c1");
      step(1, 0, 4'b1010, 4'b0101, 1, "R8 write lbe0 c2");
      step(0, 0, 4'b0000, 4'b0101, 1, "R7 R8 flags = pins");

      // R5/R4: write with only loopback enable set clears everything
      step(1, 1, 4'b0000, 4'b0101, 1, "R5 R4 lbe-only write");
      step(0, 1, 4'b0000, 4'b1111, 1, "R5 hold after lbe-only");

      // R4: rebuild clears bits whose new flag is 0
      step(1, 1, 4'b1111, 4'b1111, 1, "R4 set all");
      step(1, 1, 4'b0010, 4'b1111, 1, "R4 rebuild to cts only");
      step(0, 0, 4'b0000, 4'b1111, 0, "settle");
      step(0, 0, 4'b0000, 4'b1111, 1, "R7 R8 exit loop");
      step(0, 0, 4'b0000, 4'b1111, 1, "R7 pins ones");

      repeat (3) @(negedge clk);
      summary();
      $finish;
   end
endmodule